// File: doc/BRIEF.md
# IO Port to PCI Configuration Address Translator

This block takes IO port requests from a CPU-side interface and turns each one into a 64-bit physical address. It holds one internal 32-bit configuration address register, reached by a 4-byte access to port 0xCF8. A request on the four data ports 0xCFC to 0xCFF is routed into the PCI configuration region, using the latched register, but only while the register's top bit is set. Every other legal port is routed into the plain IO region.

Each request is accepted with a valid/ready handshake. One cycle later the block presents a response. The response carries the translated address, a kind code, a forward flag that says whether the access goes out on the physical bus or is finished locally, the echoed size and write flag, and local read data.

A separate combinational helper builds a configuration address from bus, device and function numbers. It flags any numbers it cannot encode.

Top module: `iocfg_xlate`

## Requirements
- R1: After reset, rsp_valid is 0 and the configuration address register holds 0, so a 4-byte read of port 0xCF8 returns 0.
- R2: A request with any port bit above bit 15 set gives rsp_err=1, rsp_fwd=0, rsp_kind=3, rsp_addr=0 and rsp_rdata=32'hFFFF_FFFF.
- R3: A 4-byte (req_size=4) write to port 0xCF8 stores req_wdata in the configuration address register. The response has rsp_kind=2 and rsp_fwd=0.
- R4: A 4-byte read of port 0xCF8 returns the stored register value in rsp_rdata, with rsp_kind=2 and rsp_fwd=0.
- R5: A request to ports 0xCFC..0xCFF while register bit 31 is 1 gives rsp_addr = 64'hC000_0000_0000_0000 OR register bits 30:0, with rsp_kind=1 and rsp_fwd=1.
- R6: A request to ports 0xCFC..0xCFF while register bit 31 is 0 is completed locally: rsp_kind=3, rsp_fwd=0, rsp_err=0, rsp_rdata=32'hFFFF_FFFF.
- R7: Any other legal port, including a sub-4-byte access to 0xCF8, gives rsp_addr = 64'h8000_0000_0000_0000 OR the zero-extended port, with rsp_kind=0 and rsp_fwd=1.
- R8: A request accepted on a clock edge (req_valid and req_ready both high) shows rsp_valid=1 after that edge. While rsp_valid=1 and rsp_ready=0, req_ready is 0 and every response field holds steady.
- R9: rsp_size and rsp_write echo req_size and req_write of the accepted request.
- R10: For bus 0, device below 32 and function below 8, hb_addr = 64'hC000_0000_0000_0000 OR (function << 8) OR (device << 11), and hb_err=0.
- R11: For function 8 or more, device 32 or more, or a nonzero bus, hb_err=1 and hb_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_port | input | PORT_IN_W | IO port number (legal ports fit in 16 bits) |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_addr | output | 64 | Translated physical address |
| rsp_kind | output | 2 | 0 IO, 1 config, 2 register, 3 local |
| rsp_fwd | output | 1 | 1 = forward to physical bus |
| rsp_err | output | 1 | Port out of range |
| rsp_size | output | 3 | Echoed size |
| rsp_write | output | 1 | Echoed write flag |
| rsp_rdata | output | DATA_W | Local read data |
| hb_bus | input | BUS_W | Helper bus number |
| hb_dev | input | DEV_W | Helper device number |
| hb_func | input | FN_W | Helper function number |
| hb_addr | output | 64 | Helper configuration address |
| hb_err | output | 1 | Helper input out of range |

## Verification
The bench builds the block with its default parameters. A 32-bit port input makes out-of-range port numbers possible, and 8-bit helper fields let device 32, function 8 and bus 1 be driven. Together these reach every error branch, as well as the edges device 31 and function 7. With 32-bit data, the enable bit and the full 31-bit address field can be written and observed through the config-data window.

// File: rtl/iocfg_pkg.sv
package iocfg_pkg;

  localparam logic [63:0] PFX_IO  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PFX_CFG = 64'hC000_0000_0000_0000;
  localparam logic [15:0] PORT_CADDR = 16'h0CF8;
  localparam logic [15:0] PORT_CDATA = 16'h0CFC;

  typedef enum logic [1:0] {
    K_IO    = 2'd0,
    K_CFG   = 2'd1,
    K_REG   = 2'd2,
    K_LOCAL = 2'd3
  } kind_t;

  function automatic logic [63:0] io_map(input logic [15:0] port);
    return PFX_IO | {48'd0, port};
  endfunction

  function automatic logic [63:0] cfg_map(input logic [30:0] low);
    return PFX_CFG | {33'd0, low};
  endfunction

  function automatic logic [63:0] bdf_map(input logic [4:0] dev, input logic [2:0] fn);
    return PFX_CFG | ({61'd0, fn} << 8) | ({59'd0, dev} << 11);
  endfunction

endpackage

// File: rtl/iocfg_cfgreg.sv
module iocfg_cfgreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata;
  end

  p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/iocfg_decode.sv
module iocfg_decode
  import iocfg_pkg::*;
#(
  parameter int PORT_IN_W = 32,
  parameter int DATA_W    = 32
) (
  input  logic [PORT_IN_W-1:0] port,
  input  logic [2:0]           size,
  input  logic                 write,
  input  logic [DATA_W-1:0]    cfg_q,
  output kind_t                kind,
  output logic [63:0]          addr,
  output logic                 err,
  output logic                 fwd,
  output logic [DATA_W-1:0]    rdata,
  output logic                 reg_wr
);
  logic        hi_bad, hit_reg, hit_dat, cfg_on;
  logic [15:0] p16;

  assign hi_bad  = |port[PORT_IN_W-1:16];
  assign p16     = port[15:0];
  assign hit_reg = !hi_bad && (p16 == PORT_CADDR) && (size == 3'd4);
  assign hit_dat = !hi_bad && (p16[15:2] == PORT_CDATA[15:2]);
  assign cfg_on  = cfg_q[31];

  always_comb begin
    kind   = K_IO;
    addr   = '0;
    err    = 1'b0;
    fwd    = 1'b0;
    rdata  = '0;
    reg_wr = 1'b0;
    if (hi_bad) begin
      kind  = K_LOCAL;
      err   = 1'b1;
      rdata = '1;
    end else if (hit_reg) begin
      kind   = K_REG;
      rdata  = cfg_q;
      reg_wr = write;
    end else if (hit_dat) begin
      if (cfg_on) begin
        kind = K_CFG;
        addr = cfg_map(cfg_q[30:0]);
        fwd  = 1'b1;
      end else begin
        kind  = K_LOCAL;
        rdata = '1;
      end
    end else begin
      kind = K_IO;
      addr = io_map(p16);
      fwd  = 1'b1;
    end
  end
endmodule

// File: rtl/iocfg_bdf.sv
module iocfg_bdf
  import iocfg_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int DEV_W = 8,
  parameter int FN_W  = 8
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  output logic [63:0]      addr,
  output logic             err
);
  localparam logic [DEV_W-1:0] DEV_LIM = DEV_W'(32);
  localparam logic [FN_W-1:0]  FN_LIM  = FN_W'(8);

  assign err  = (bus != '0) || (dev >= DEV_LIM) || (fn >= FN_LIM);
  assign addr = err ? 64'd0 : bdf_map(dev[4:0], fn[2:0]);
endmodule

// File: rtl/iocfg_xlate.sv
module iocfg_xlate
  import iocfg_pkg::*;
#(
  parameter int PORT_IN_W = 32,
  parameter int DATA_W    = 32,
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 8,
  parameter int FN_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PORT_IN_W-1:0] req_port,
  input  logic [2:0]           req_size,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [63:0]          rsp_addr,
  output logic [1:0]           rsp_kind,
  output logic                 rsp_fwd,
  output logic                 rsp_err,
  output logic [2:0]           rsp_size,
  output logic                 rsp_write,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic [BUS_W-1:0]     hb_bus,
  input  logic [DEV_W-1:0]     hb_dev,
  input  logic [FN_W-1:0]      hb_func,
  output logic [63:0]          hb_addr,
  output logic                 hb_err
);
  // named internal events
  logic              accept;
  logic              reg_wr;
  logic [DATA_W-1:0] cfg_q;
  kind_t             d_kind;
  logic [63:0]       d_addr;
  logic              d_err, d_fwd;
  logic [DATA_W-1:0] d_rdata;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  iocfg_decode #(.PORT_IN_W(PORT_IN_W), .DATA_W(DATA_W)) u_dec (
    .port(req_port), .size(req_size), .write(req_write), .cfg_q(cfg_q),
    .kind(d_kind), .addr(d_addr), .err(d_err), .fwd(d_fwd),
    .rdata(d_rdata), .reg_wr(reg_wr)
  );

  iocfg_cfgreg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(accept && reg_wr),
    .wdata(req_wdata), .q(cfg_q)
  );

  iocfg_bdf #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W)) u_bdf (
    .bus(hb_bus), .dev(hb_dev), .fn(hb_func), .addr(hb_addr), .err(hb_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_kind  <= K_IO;
      rsp_fwd   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_size  <= '0;
      rsp_write <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= d_addr;
      rsp_kind  <= d_kind;
      rsp_fwd   <= d_fwd;
      rsp_err   <= d_err;
      rsp_size  <= req_size;
      rsp_write <= req_write;
      rsp_rdata <= d_rdata;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_kind)
                                   && $stable(rsp_rdata)));
  p_err_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (!rsp_fwd && rsp_kind == 2'd3));
  p_cfg_pfx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd1) |-> (rsp_addr[63:62] == 2'b11 && rsp_fwd));
  p_io_pfx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd0) |-> (rsp_addr[63:16] == 48'h8000_0000_0000));
  p_helper_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hb_err |-> (hb_addr == 64'd0));
endmodule

// File: tb/test_iocfg_xlate.sv
module test_iocfg_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_port = '0;
  logic [2:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic [1:0]  rsp_kind;
  logic        rsp_fwd, rsp_err, rsp_write;
  logic [2:0]  rsp_size;
  logic [31:0] rsp_rdata;
  logic [7:0]  hb_bus = '0, hb_dev = '0, hb_func = '0;
  logic [63:0] hb_addr;
  logic        hb_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iocfg_xlate i_iocfg_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_kind(rsp_kind), .rsp_fwd(rsp_fwd),
    .rsp_err(rsp_err), .rsp_size(rsp_size), .rsp_write(rsp_write),
    .rsp_rdata(rsp_rdata), .hb_bus(hb_bus), .hb_dev(hb_dev),
    .hb_func(hb_func), .hb_addr(hb_addr), .hb_err(hb_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, accept on posedge, sample at following negedge
  task automatic xfer(input logic [31:0] p, input logic [2:0] sz,
                      input logic wr, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_port = p; req_size = sz; req_write = wr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    xfer(32'h0CF8, 3'd4, 1'b0, '0);
    chk("R1 reg zero", {32'd0, rsp_rdata}, 64'd0);
    chk("R4 kind reg", {62'd0, rsp_kind}, 64'd2);
  endtask

  task automatic t_io;
    xfer(32'h0080, 3'd1, 1'b1, 32'h55);
    chk("R7 io addr", rsp_addr, 64'h8000_0000_0000_0080);
    chk("R7 fwd kind", {61'd0, rsp_fwd, rsp_kind}, {61'd0, 1'b1, 2'd0});
    chk("R9 size/write", {60'd0, rsp_size, rsp_write}, {60'd0, 3'd1, 1'b1});
    xfer(32'hFFFF, 3'd2, 1'b0, '0);
    chk("R7 top port", rsp_addr, 64'h8000_0000_0000_FFFF);
    chk("R9 size read", {60'd0, rsp_size, rsp_write}, {60'd0, 3'd2, 1'b0});
    xfer(32'h0CFB, 3'd1, 1'b0, '0);
    chk("R7 below window", rsp_addr, 64'h8000_0000_0000_0CFB);
    xfer(32'h0CF8, 3'd2, 1'b1, 32'hFFFF_FFFF);
    chk("R7 narrow cf8", rsp_addr, 64'h8000_0000_0000_0CF8);
    xfer(32'h0CF8, 3'd4, 1'b0, '0);
    chk("R7 narrow cf8 left reg", {32'd0, rsp_rdata}, 64'd0);
  endtask

  task automatic t_cfg_on;
    xfer(32'h0CF8, 3'd4, 1'b1, 32'h8000_1234);
    chk("R3 write kind/fwd", {61'd0, rsp_fwd, rsp_kind}, {61'd0, 1'b0, 2'd2});
    xfer(32'h0CF8, 3'd4, 1'b0, '0);
    chk("R4 readback", {32'd0, rsp_rdata}, 64'h8000_1234);
    xfer(32'h0CFE, 3'd2, 1'b0, '0);
    chk("R5 cfg addr", rsp_addr, 64'hC000_0000_0000_1234);
    chk("R5 fwd kind", {61'd0, rsp_fwd, rsp_kind}, {61'd0, 1'b1, 2'd1});
    xfer(32'h0CF8, 3'd4, 1'b1, 32'hFFFF_FFFF);
    xfer(32'h0CFF, 3'd1, 1'b1, 32'h1);
    chk("R5 full field", rsp_addr, 64'hC000_0000_7FFF_FFFF);
  endtask

  task automatic t_cfg_off;
    xfer(32'h0CF8, 3'd4, 1'b1, 32'h0000_1234);
    xfer(32'h0CFD, 3'd1, 1'b0, '0);
    chk("R6 kind/fwd/err", {60'd0, rsp_err, rsp_fwd, rsp_kind}, {60'd0, 1'b0, 1'b0, 2'd3});
    chk("R6 rdata ones", {32'd0, rsp_rdata}, 64'hFFFF_FFFF);
  endtask

  task automatic t_port_err;
    xfer(32'h0001_0080, 3'd1, 1'b0, '0);
    chk("R2 err/fwd/kind", {60'd0, rsp_err, rsp_fwd, rsp_kind}, {60'd0, 1'b1, 1'b0, 2'd3});
    chk("R2 addr", rsp_addr, 64'd0);
    chk("R2 rdata", {32'd0, rsp_rdata}, 64'hFFFF_FFFF);
    xfer(32'h8000_0CF8, 3'd4, 1'b1, 32'h8000_0001);
    xfer(32'h0CF8, 3'd4, 1'b0, '0);
    chk("R2 reg untouched", {32'd0, rsp_rdata}, 64'h0000_1234);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    xfer(32'h0040, 3'd1, 1'b0, '0);
    chk("R8 valid after accept", {63'd0, rsp_valid}, 64'd1);
    chk("R8 ready low", {63'd0, req_ready}, 64'd0);
    req_valid = 1'b1; req_port = 32'h0041;
    @(negedge clk);
    chk("R8 held addr", rsp_addr, 64'h8000_0000_0000_0040);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 next accepted", rsp_addr, 64'h8000_0000_0000_0041);
    @(negedge clk);
    chk("R8 drained", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_helper;
    hb_bus = 8'd0; hb_dev = 8'd5; hb_func = 8'd3; #1;
    chk("R10 bdf 5/3", hb_addr, 64'hC000_0000_0000_2B00);
    chk("R10 no err", {63'd0, hb_err}, 64'd0);
    hb_dev = 8'd31; hb_func = 8'd7; #1;
    chk("R10 bdf edge", hb_addr, 64'hC000_0000_0000_FF00);
    hb_dev = 8'd0; hb_func = 8'd8; #1;
    chk("R11 func8", {hb_err, hb_addr[62:0]}, 64'h8000_0000_0000_0000);
    hb_dev = 8'd32; hb_func = 8'd0; #1;
    chk("R11 dev32", {hb_err, hb_addr[62:0]}, 64'h8000_0000_0000_0000);
    hb_dev = 8'd1; hb_bus = 8'd1; #1;
    chk("R11 bus1", {hb_err, hb_addr[62:0]}, 64'h8000_0000_0000_0000);
    hb_bus = 8'd0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_io();
    t_cfg_on();
    t_cfg_off();
    t_port_err();
    t_backpressure();
    t_helper();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule